// File: doc/BRIEF.md
# Masked Interrupt Pending Controller

This block gathers interrupt requests from up to eight sources into a pending register and drives one interrupt line toward the processor. A source is allowed to reach the line only when its bit in an enable vector is set. Software programs that vector through a mask port. The byte written to the mask port is inverted before it is stored, so a written 1 blocks a source and a written 0 lets it through. The output is registered. It is recomputed every cycle from the pending register and the enable vector, so a mask write has an effect on the next cycle.

Peripherals act on the pending bits directly with set and clear vectors. The host clears one pending bit at a time by writing the bit's index to the acknowledge port. A second mask port and a second status port exist only so that older software keeps working. The second mask holds its byte as written, and the second status port always reads zero. Neither of them can raise the interrupt.

The host port is a plain synchronous register interface. Read data is registered and appears in the cycle after the read strobe. A wide (64-bit) read is defined only for the primary status port, where it returns the pending byte zero-extended.

Top module: `irq_pend_ctrl`

## Requirements
- R1: A write to address 0 (primary mask) stores the bitwise inverse of the written byte as the enable vector. A narrow read of address 0 returns the inverse of the enable vector, which is the byte last written.
- R2: `irqOut` is high in the cycle after any edge where (pending AND enable) becomes nonzero. It is low in the cycle after that AND becomes zero.
- R3: After a mask write, the output follows the new enable vector on the next cycle. Unmasking a pending bit raises `irqOut`, and masking every pending bit drops it.
- R4: A write to address 1 (acknowledge) clears the pending bit whose index is in write data bits [3:0]. Index values 8 to 15 change no pending bit.
- R5: Each bit of `srcSet` sets the matching pending bit. Each bit of `srcClr` clears the matching pending bit.
- R6: In one cycle, a pending bit is first cleared by an acknowledge, then cleared by `srcClr`, then set by `srcSet`. So a set always wins over a clear or an acknowledge of the same bit.
- R7: A write to address 2 (secondary mask) stores the byte unmodified. A narrow read of address 2 returns that byte. This register never changes the enable vector or `irqOut`.
- R8: A read of address 3 (secondary status) returns zero.
- R9: A read of address 1 returns the pending register in bits [7:0] with bits [63:8] zero. This holds for narrow reads and for wide reads (`busWide`=1). A wide read of any other address returns zero.
- R10: After reset the pending register and the enable vector are zero. `irqOut` is low, and a mask read returns 0xFF.
- R11: `busRdata` is registered. It shows the value selected by the read in the previous cycle, based on the state before that cycle's edge. It is zero after a cycle without a read and after a read of an unmapped address.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| busAddr | input | 4 | Register address |
| busWe | input | 1 | Write strobe |
| busWdata | input | 8 | Write data |
| busRe | input | 1 | Read strobe |
| busWide | input | 1 | Read is a 64-bit access |
| busRdata | output | 64 | Registered read data |
| srcSet | input | 8 | Per-source pending set vector |
| srcClr | input | 8 | Per-source pending clear vector |
| irqOut | output | 1 | Interrupt toward the processor |

## Verification
Three things can hit the same pending bit in one cycle: a host acknowledge, a peripheral set, and a peripheral clear. A mask write can also land in the same cycle as a pending-bit change. Directed steps put an acknowledge, a set and a clear on one index in a single cycle. The random phase drives sparse set and clear vectors together with random writes to all ports. After every cycle, a bench model applies the ordering acknowledge, then clear, then set, and the pending read-back and `irqOut` are compared against it.

// File: rtl/irq_pend_pkg.sv
package irq_pend_pkg;
  localparam int DATA_W = 8;
  localparam int IDX_W  = 4;

  typedef enum logic [2:0] {
    RD_ZERO     = 3'd0,
    RD_MASK     = 3'd1,
    RD_STAT     = 3'd2,
    RD_STAT_WIDE = 3'd3,
    RD_SEC_MASK = 3'd4
  } rdSel_e;

  typedef struct packed {
    logic              wrMask;
    logic              wrAck;
    logic              wrSecMask;
    logic [IDX_W-1:0]  ackIdx;
    logic [DATA_W-1:0] wrData;
    logic              rdEn;
    rdSel_e            rdSel;
  } ctlStrobe_t;
endpackage

// File: rtl/irq_pend_ctl.sv
module irq_pend_ctl
  import irq_pend_pkg::*;
#(
  parameter int ADDR_W     = 4,
  parameter int MASK_OFS   = 0,
  parameter int STAT_OFS   = 1,
  parameter int SMASK_OFS  = 2,
  parameter int SSTAT_OFS  = 3
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [ADDR_W-1:0] busAddr,
  input  logic              busWe,
  input  logic [DATA_W-1:0] busWdata,
  input  logic              busRe,
  input  logic              busWide,
  output ctlStrobe_t        strobe
);
  localparam logic [ADDR_W-1:0] MaskA  = ADDR_W'(MASK_OFS);
  localparam logic [ADDR_W-1:0] StatA  = ADDR_W'(STAT_OFS);
  localparam logic [ADDR_W-1:0] SMaskA = ADDR_W'(SMASK_OFS);
  localparam logic [ADDR_W-1:0] SStatA = ADDR_W'(SSTAT_OFS);

  logic hitMask, hitStat, hitSMask, hitSStat;

  always_comb begin
    hitMask  = (busAddr == MaskA);
    hitStat  = (busAddr == StatA);
    hitSMask = (busAddr == SMaskA);
    hitSStat = (busAddr == SStatA);
  end

  always_comb begin
    strobe.wrMask    = busWe && hitMask;
    strobe.wrAck     = busWe && hitStat;
    strobe.wrSecMask = busWe && hitSMask;
    strobe.ackIdx    = busWdata[IDX_W-1:0];
    strobe.wrData    = busWdata;
    strobe.rdEn      = busRe;
    strobe.rdSel     = RD_ZERO;
    if (busRe) begin
      if (busWide) begin
        if (hitStat) strobe.rdSel = RD_STAT_WIDE;
      end else begin
        if (hitMask)       strobe.rdSel = RD_MASK;
        else if (hitStat)  strobe.rdSel = RD_STAT;
        else if (hitSMask) strobe.rdSel = RD_SEC_MASK;
      end
    end
  end

  // R8
  sec_stat_zero_chk: assert property (@(posedge clk) disable iff (!rstN)
    (busRe && hitSStat) |-> (strobe.rdSel == RD_ZERO));

  // R4
  ack_strobe_chk: assert property (@(posedge clk) disable iff (!rstN)
    strobe.wrAck |-> (!strobe.wrMask && !strobe.wrSecMask));
endmodule

// File: rtl/irq_pend_dp.sv
module irq_pend_dp
  import irq_pend_pkg::*;
#(
  parameter int NSRC = 8,
  parameter int RD_W = 64
) (
  input  logic            clk,
  input  logic            rstN,
  input  ctlStrobe_t      strobe,
  input  logic [NSRC-1:0] srcSet,
  input  logic [NSRC-1:0] srcClr,
  output logic            irqOut,
  output logic [RD_W-1:0] rdData
);
  localparam int PAD_W  = RD_W - NSRC;
  localparam int SPAD_W = RD_W - DATA_W;

  logic [NSRC-1:0]   pendQ, pendD;
  logic [NSRC-1:0]   enQ, enD;
  logic [DATA_W-1:0] secQ, secD;
  logic [NSRC-1:0]   ackVec;
  logic              irqQ;
  logic [RD_W-1:0]   rdQ, rdD;

  for (genvar i = 0; i < NSRC; i++) begin : g_ackDec
    assign ackVec[i] = strobe.wrAck && (strobe.ackIdx == IDX_W'(i));
  end

  always_comb begin
    pendD = pendQ & ~ackVec;
    pendD = pendD & ~srcClr;
    pendD = pendD | srcSet;
    enD   = strobe.wrMask ? ~strobe.wrData[NSRC-1:0] : enQ;
    secD  = strobe.wrSecMask ? strobe.wrData : secQ;
  end

  always_comb begin
    rdD = '0;
    if (strobe.rdEn) begin
      unique case (strobe.rdSel)
        RD_MASK:      rdD = {{PAD_W{1'b0}}, ~enQ};
        RD_STAT,
        RD_STAT_WIDE: rdD = {{PAD_W{1'b0}}, pendQ};
        RD_SEC_MASK:  rdD = {{SPAD_W{1'b0}}, secQ};
        default:      rdD = '0;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      pendQ <= '0;
      enQ   <= '0;
      secQ  <= '0;
      irqQ  <= 1'b0;
      rdQ   <= '0;
    end else begin
      pendQ <= pendD;
      enQ   <= enD;
      secQ  <= secD;
      irqQ  <= |(pendD & enD);
      rdQ   <= rdD;
    end
  end

  assign irqOut = irqQ;
  assign rdData = rdQ;

  // R2
  irq_follow_chk: assert property (@(posedge clk) disable iff (!rstN)
    irqOut == (|(pendQ & enQ)));

  // R1
  mask_invert_chk: assert property (@(posedge clk) disable iff (!rstN)
    strobe.wrMask |=> (enQ == ~$past(strobe.wrData[NSRC-1:0])));

  // R6
  set_wins_chk: assert property (@(posedge clk) disable iff (!rstN)
    (|srcSet) |=> ((pendQ & $past(srcSet)) == $past(srcSet)));

  // R4
  ack_clear_chk: assert property (@(posedge clk) disable iff (!rstN)
    (|(ackVec & ~srcSet)) |=> ((pendQ & $past(ackVec & ~srcSet)) == '0));

  // R7
  sec_no_effect_chk: assert property (@(posedge clk) disable iff (!rstN)
    strobe.wrSecMask |=> ($stable(enQ) && secQ == $past(strobe.wrData)));

  // R9
  wide_zext_chk: assert property (@(posedge clk) disable iff (!rstN)
    1'b1 |=> (rdData[RD_W-1:NSRC] == '0 || $past(strobe.rdSel) == RD_MASK));
endmodule

// File: rtl/irq_pend_ctrl.sv
module irq_pend_ctrl
  import irq_pend_pkg::*;
#(
  parameter int ADDR_W = 4,
  parameter int NSRC   = 8,
  parameter int RD_W   = 64
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [ADDR_W-1:0] busAddr,
  input  logic              busWe,
  input  logic [7:0]        busWdata,
  input  logic              busRe,
  input  logic              busWide,
  output logic [RD_W-1:0]   busRdata,
  input  logic [NSRC-1:0]   srcSet,
  input  logic [NSRC-1:0]   srcClr,
  output logic              irqOut
);
  ctlStrobe_t strobe;

  irq_pend_ctl #(.ADDR_W(ADDR_W)) ctl_i (
    .clk(clk), .rstN(rstN), .busAddr(busAddr), .busWe(busWe),
    .busWdata(busWdata), .busRe(busRe), .busWide(busWide), .strobe(strobe)
  );

  irq_pend_dp #(.NSRC(NSRC), .RD_W(RD_W)) dp_i (
    .clk(clk), .rstN(rstN), .strobe(strobe), .srcSet(srcSet),
    .srcClr(srcClr), .irqOut(irqOut), .rdData(busRdata)
  );
endmodule

// File: tb/irq_pend_ctrl_tb.sv
`timescale 1ns/1ps
module irq_pend_ctrl_tb_top;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic [3:0]  busAddr = '0;
  logic        busWe = 1'b0;
  logic [7:0]  busWdata = '0;
  logic        busRe = 1'b0;
  logic        busWide = 1'b0;
  logic [63:0] busRdata;
  logic [7:0]  srcSet = '0;
  logic [7:0]  srcClr = '0;
  logic        irqOut;

  int total = 0;
  int bad = 0;
  bit done = 1'b0;

  logic [7:0] mPend = '0, mEn = '0, mSec = '0;

  always #2 clk = ~clk;

  irq_pend_ctrl dut_i (
    .clk(clk), .rstN(rstN), .busAddr(busAddr), .busWe(busWe),
    .busWdata(busWdata), .busRe(busRe), .busWide(busWide),
    .busRdata(busRdata), .srcSet(srcSet), .srcClr(srcClr), .irqOut(irqOut)
  );

  function automatic logic [63:0] expRead(input logic [3:0] a, input logic w);
    if (w) return (a == 4'd1) ? {56'd0, mPend} : 64'd0;
    case (a)
      4'd0: return {56'd0, ~mEn};
      4'd1: return {56'd0, mPend};
      4'd2: return {56'd0, mSec};
      default: return 64'd0;
    endcase
  endfunction

  task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // One cycle: drive at negedge, update model, check after the next edge.
  task automatic step(input string req, input logic [3:0] a, input logic we,
                      input logic re, input logic wd, input logic [7:0] d,
                      input logic [7:0] st, input logic [7:0] cl);
    logic [63:0] eRd;
    logic [7:0]  ack;
    busAddr = a; busWe = we; busRe = re; busWide = wd; busWdata = d;
    srcSet = st; srcClr = cl;
    eRd = re ? expRead(a, wd) : 64'd0;
    ack = (we && a == 4'd1 && d[3:0] < 4'd8) ? (8'd1 << d[3:0]) : 8'd0;
    mPend = ((mPend & ~ack) & ~cl) | st;
    if (we && a == 4'd0) mEn = ~d;
    if (we && a == 4'd2) mSec = d;
    @(posedge clk);
    @(negedge clk);
    busWe = 1'b0; busRe = 1'b0; busWide = 1'b0; srcSet = '0; srcClr = '0;
    check({req, " irq"}, {63'd0, irqOut}, {63'd0, |(mPend & mEn)});
    check({req, " rdata"}, busRdata, eRd);
  endtask

  task automatic idle(input string req);
    step(req, 4'd0, 1'b0, 1'b0, 1'b0, 8'd0, 8'd0, 8'd0);
  endtask

  task automatic rd(input string req, input logic [3:0] a, input logic wd);
    step(req, a, 1'b0, 1'b1, wd, 8'd0, 8'd0, 8'd0);
  endtask

  task automatic wr(input string req, input logic [3:0] a, input logic [7:0] d);
    step(req, a, 1'b1, 1'b0, 1'b0, d, 8'd0, 8'd0);
  endtask

  task automatic finishRun();
    if (!done) begin
      done = 1'b1;
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    total++; bad++;
    $display("FAIL watchdog actual=timeout expected=finish");
    finishRun();
  end

  initial begin
    void'($urandom(32'h5eed_1234));
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    // R10 reset state
    check("R10 irq reset", {63'd0, irqOut}, 64'd0);
    check("R10 rdata reset", busRdata, 64'd0);
    rd("R10", 4'd0, 1'b0);
    check("R10 mask reads FF", busRdata, 64'hFF);
    rd("R10", 4'd1, 1'b0);
    check("R10 pend zero", busRdata, 64'd0);
    // R1 mask write and readback
    wr("R1", 4'd0, 8'hFE);
    rd("R1", 4'd0, 1'b0);
    check("R1 readback", busRdata, 64'hFE);
    // R5 set raises output (R2)
    step("R5", 4'd0, 1'b0, 1'b0, 1'b0, 8'd0, 8'h03, 8'd0);
    check("R2 irq high", {63'd0, irqOut}, 64'd1);
    // R3 masking drops, unmasking raises
    wr("R3", 4'd0, 8'hFF);
    check("R3 masked low", {63'd0, irqOut}, 64'd0);
    wr("R3", 4'd0, 8'hFD);
    check("R3 unmasked high", {63'd0, irqOut}, 64'd1);
    // R4 acknowledge by index, out-of-range index ignored
    wr("R4", 4'd1, 8'h09);
    rd("R4", 4'd1, 1'b0);
    check("R4 idx9 ignored", busRdata, 64'h03);
    wr("R4", 4'd1, 8'hF1);
    rd("R4", 4'd1, 1'b0);
    check("R4 idx1 cleared", busRdata, 64'h01);
    check("R4 irq low", {63'd0, irqOut}, 64'd0);
    // R5 clear input
    step("R5", 4'd0, 1'b0, 1'b0, 1'b0, 8'd0, 8'd0, 8'h01);
    rd("R5", 4'd1, 1'b0);
    check("R5 cleared", busRdata, 64'd0);
    // R6 set vs clear vs ack on the same bit
    step("R6", 4'd1, 1'b1, 1'b0, 1'b0, 8'h03, 8'h08, 8'h08);
    rd("R6", 4'd1, 1'b0);
    check("R6 set wins", busRdata, 64'h08);
    step("R6", 4'd1, 1'b1, 1'b0, 1'b0, 8'h03, 8'd0, 8'd0);
    rd("R6", 4'd1, 1'b0);
    check("R6 ack alone", busRdata, 64'd0);
    // R7 secondary mask never enables
    step("R7", 4'd0, 1'b1, 1'b0, 1'b0, 8'hFF, 8'hA0, 8'd0);
    wr("R7", 4'd2, 8'h00);
    check("R7 irq stays low", {63'd0, irqOut}, 64'd0);
    rd("R7", 4'd2, 1'b0);
    check("R7 sec readback", busRdata, 64'd0);
    wr("R7", 4'd2, 8'h5C);
    rd("R7", 4'd2, 1'b0);
    check("R7 sec byte", busRdata, 64'h5C);
    rd("R7", 4'd0, 1'b0);
    check("R7 mask unchanged", busRdata, 64'hFF);
    // R8 secondary status
    rd("R8", 4'd3, 1'b0);
    check("R8 zero", busRdata, 64'd0);
    // R9 wide reads
    rd("R9", 4'd1, 1'b1);
    check("R9 wide status", busRdata, 64'hA0);
    rd("R9", 4'd2, 1'b1);
    check("R9 wide other", busRdata, 64'd0);
    // R11 no read, unmapped read
    idle("R11");
    check("R11 idle zero", busRdata, 64'd0);
    rd("R11", 4'd9, 1'b0);
    check("R11 unmapped", busRdata, 64'd0);
    // Random mix, R2 R5 R6 R11 model compare
    for (int i = 0; i < 600; i++) begin
      logic [3:0] a;
      logic [7:0] st, cl;
      a  = 4'($urandom_range(0, 5));
      st = (($urandom & 3) == 0) ? 8'($urandom) & 8'($urandom) : 8'd0;
      cl = (($urandom & 3) == 0) ? 8'($urandom) & 8'($urandom) : 8'd0;
      step("R2 R6 random", a, 1'($urandom), 1'($urandom), 1'($urandom),
           8'($urandom), st, cl);
    end
    finishRun();
  end
endmodule